// File: doc/BRIEF.md
# Bandwidth Share Bus Arbiter

This block decides which of four bus masters owns a shared on-chip bus. Each master is configured with a target percentage of bus time. A larger target also gives that master higher priority. The arbiter counts how many cycles each master held the bus over a sliding window. When several masters compete, it favours the ones that are currently getting less than their target. A lone requester is granted at once, with no share evaluation.

A mode input selects between two behaviours. In static mode the targets are used exactly as configured. In dynamic mode, a master that has waited too long borrows a fixed number of percentage points from a master of higher priority. The loan is handed back as soon as the waiting ends.

Once a grant is issued, it stays with its master until that master signals the end of its transaction. A new arbitration then starts after one idle cycle. The bus datapath, address decoding and slaves lie outside this block.

Top module: `bw_share_arbiter`

## Requirements
- R1: The grant vector is one-hot or all-zero at every cycle, and it is all-zero during and directly after reset.
- R2: A granted master keeps its grant while its done bit is low. When the granted master's done bit is high at a clock edge, the grant is cleared at that edge.
- R3: A grant is issued only at an edge where no grant is held and at least one request is high, and it goes to a master requesting at that edge. The bit for master i is bit i of the request, done and grant vectors.
- R4: When exactly one request bit is high, that master is granted at the next edge, whatever its share (including a share of 0).
- R5: When several masters request and at least one of them is below target, the grant goes to the below-target requester with the largest configured share. On equal shares the lower index wins.
- R6: When several masters request and none is below target, the grant goes to the requester with the largest configured share. On equal shares the lower index wins.
- R7: A master's measured usage is the number of cycles it held the grant within the last WINDOW cycles (default 256). It is below target when usage*100 < effective_share*WINDOW. Usage older than the window no longer counts.
- R8: In static mode (mode input low), every effective share equals the configured share. Config bits [7i+6:7i] hold master i's share in percent.
- R9: In dynamic mode, a master that has been requesting without a grant for more than STARVE_CYCLES cycles (default 64) borrows min(5, lender's effective share) percentage points. The lender is the non-borrowing master of highest priority that outranks the borrower and has a non-zero effective share. The sum of the effective shares always equals the sum of the configured shares.
- R10: A loan is returned to its lender when the borrower is granted, when it drops its request, or when static mode is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dyn_mode | input | 1 | 1 = dynamic mode with share borrowing, 0 = static targets |
| req_i | input | 4 | Request bit per master |
| done_i | input | 4 | Transaction-finished bit per master |
| share_cfg_i | input | 28 | Target share per master, 7 bits each, in percent |
| grant_o | output | 4 | One-hot grant, or zero when the bus is idle |

## Verification
The assertions assume the following about the inputs:
- Each configured share is at most 100.
- The shares add up to 100.
- Shares change only while the arbiter is in reset.
- A done bit is raised only by the master that holds the grant.

Under these assumptions, the conservation and static-equality checks on the effective shares are meaningful. The stimulus reprograms shares only inside a reset, keeps every share set summing to 100, and drives done only for the granted master. Inputs change on falling edges, away from the sampling edge.

// File: rtl/bwshare_pkg.sv
package bwshare_pkg;

    localparam int NM       = 4;
    localparam int SHARE_W  = 7;
    localparam int EFF_W    = 8;
    localparam int IDX_W    = 2;
    localparam int PCT_FULL = 100;

    typedef logic [NM-1:0]                 mvec_t;
    typedef logic [SHARE_W-1:0]            share_t;
    typedef logic [EFF_W-1:0]              eff_t;
    typedef logic [NM-1:0][SHARE_W-1:0]    share_vec_t;
    typedef logic [NM-1:0][EFF_W-1:0]      eff_vec_t;

    // one slot of the usage history: who held the bus in that cycle
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } slot_t;

    // an outstanding loan held by a borrower
    typedef struct packed {
        eff_t             amt;
        logic [IDX_W-1:0] src;
    } loan_t;

    function automatic logic [IDX_W-1:0] onehot_to_idx(mvec_t v);
        logic [IDX_W-1:0] r = '0;
        for (int i = 0; i < NM; i++)
            if (v[i]) r = IDX_W'(i);
        return r;
    endfunction

    // a outranks b: larger share, or equal share with lower index
    function automatic logic outranks(share_t sa, int ia, share_t sb, int ib);
        return (sa > sb) || ((sa == sb) && (ia < ib));
    endfunction

    // highest-priority candidate by configured share, ties to lower index
    function automatic mvec_t pick_top(mvec_t cand, share_vec_t sh);
        mvec_t r = '0;
        int best = -1;
        for (int i = 0; i < NM; i++)
            if (cand[i] && (best < 0 || sh[i] > sh[best]))
                best = i;
        if (best >= 0) r[best] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/bw_window_meter.sv
module bw_window_meter
    import bwshare_pkg::*;
#(
    parameter int WINDOW = 256,
    parameter int CNT_W  = 9
) (
    input  logic                      clk,
    input  logic                      rst,
    input  mvec_t                     grant,
    output logic [NM-1:0][CNT_W-1:0]  usage
);
    localparam int PTR_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;

    slot_t            hist [WINDOW];
    logic [PTR_W-1:0] ptr_q;
    slot_t            oldest;
    slot_t            newest;

    always_comb begin
        oldest       = hist[ptr_q];
        newest.valid = |grant;
        newest.idx   = onehot_to_idx(grant);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            usage <= '0;
            for (int k = 0; k < WINDOW; k++) hist[k] <= '0;
        end else begin
            hist[ptr_q] <= newest;
            ptr_q <= (ptr_q == PTR_W'(WINDOW - 1)) ? '0 : ptr_q + 1'b1;
            for (int i = 0; i < NM; i++) begin
                usage[i] <= usage[i]
                          + CNT_W'(grant[i])
                          - CNT_W'(oldest.valid && (oldest.idx == IDX_W'(i)));
            end
        end
    end
endmodule

// File: rtl/share_lender.sv
module share_lender
    import bwshare_pkg::*;
#(
    parameter int STARVE_CYCLES = 64,
    parameter int BORROW_STEP   = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dyn_mode,
    input  mvec_t      req,
    input  mvec_t      grant,
    input  share_vec_t share,
    output eff_vec_t   eff
);
    localparam int WAIT_W = $clog2(STARVE_CYCLES + 2);

    logic [WAIT_W-1:0] wait_q [NM];
    loan_t             loan_q [NM];
    logic [NM-1:0]     starving;
    logic              bor_found, lend_found, do_borrow;
    logic [IDX_W-1:0]  bor, lend;
    eff_t              amt;

    // effective share = configured + borrowed - lent
    always_comb begin
        for (int i = 0; i < NM; i++) begin
            eff_t acc;
            acc = EFF_W'(share[i]) + loan_q[i].amt;
            for (int b = 0; b < NM; b++)
                if (b != i && loan_q[b].amt != '0 && loan_q[b].src == IDX_W'(i))
                    acc = acc - loan_q[b].amt;
            eff[i] = acc;
        end
    end

    always_comb begin
        for (int i = 0; i < NM; i++)
            starving[i] = wait_q[i] > WAIT_W'(STARVE_CYCLES);
        bor_found = 1'b0;
        bor       = '0;
        for (int i = 0; i < NM; i++)
            if (!bor_found && dyn_mode && starving[i] && req[i] && !grant[i]
                && loan_q[i].amt == '0) begin
                bor_found = 1'b1;
                bor       = IDX_W'(i);
            end
        lend_found = 1'b0;
        lend       = '0;
        for (int j = 0; j < NM; j++)
            if (IDX_W'(j) != bor && loan_q[j].amt == '0 && eff[j] != '0
                && outranks(share[j], j, share[bor], int'(bor))
                && (!lend_found || share[j] > share[lend])) begin
                lend_found = 1'b1;
                lend       = IDX_W'(j);
            end
        amt       = (eff[lend] < EFF_W'(BORROW_STEP)) ? eff[lend] : EFF_W'(BORROW_STEP);
        do_borrow = bor_found && lend_found;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NM; i++) begin
                wait_q[i] <= '0;
                loan_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NM; i++) begin
                if (req[i] && !grant[i]) begin
                    if (!(&wait_q[i])) wait_q[i] <= wait_q[i] + 1'b1;
                end else begin
                    wait_q[i] <= '0;
                end
                if (loan_q[i].amt != '0 && (!dyn_mode || grant[i] || !req[i]))
                    loan_q[i] <= '0;
            end
            if (do_borrow) begin
                loan_q[bor].amt <= amt;
                loan_q[bor].src <= lend;
            end
        end
    end
endmodule

// File: rtl/grant_picker.sv
module grant_picker
    import bwshare_pkg::*;
#(
    parameter int WINDOW = 256,
    parameter int CNT_W  = 9
) (
    input  mvec_t                     req,
    input  share_vec_t                share,
    input  eff_vec_t                  eff,
    input  logic [NM-1:0][CNT_W-1:0]  usage,
    output mvec_t                     pick
);
    mvec_t below;
    mvec_t hungry;

    always_comb begin
        for (int i = 0; i < NM; i++)
            below[i] = (32'(usage[i]) * 32'(PCT_FULL)) < (32'(eff[i]) * 32'(WINDOW));
        hungry = req & below;
        if ($onehot(req))
            pick = req;
        else if (hungry != '0)
            pick = pick_top(hungry, share);
        else
            pick = pick_top(req, share);
    end
endmodule

// File: rtl/bw_share_arbiter.sv
module bw_share_arbiter
    import bwshare_pkg::*;
#(
    parameter int WINDOW        = 256,
    parameter int STARVE_CYCLES = 64,
    parameter int BORROW_STEP   = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    dyn_mode,
    input  logic [NM-1:0]           req_i,
    input  logic [NM-1:0]           done_i,
    input  logic [NM*SHARE_W-1:0]   share_cfg_i,
    output logic [NM-1:0]           grant_o
);
    localparam int CNT_W = $clog2(WINDOW + 1);

    share_vec_t                share_vec;
    eff_vec_t                  eff_vec;
    logic [NM-1:0][CNT_W-1:0]  usage_vec;
    mvec_t                     pick_vec;
    mvec_t                     grant_q;

    assign share_vec = share_vec_t'(share_cfg_i);
    assign grant_o   = grant_q;

    bw_window_meter #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_meter (
        .clk   (clk),
        .rst   (rst),
        .grant (grant_q),
        .usage (usage_vec)
    );

    share_lender #(.STARVE_CYCLES(STARVE_CYCLES), .BORROW_STEP(BORROW_STEP)) u_lend (
        .clk      (clk),
        .rst      (rst),
        .dyn_mode (dyn_mode),
        .req      (req_i),
        .grant    (grant_q),
        .share    (share_vec),
        .eff      (eff_vec)
    );

    grant_picker #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_pick (
        .req   (req_i),
        .share (share_vec),
        .eff   (eff_vec),
        .usage (usage_vec),
        .pick  (pick_vec)
    );

    always_ff @(posedge clk) begin
        if (rst)
            grant_q <= '0;
        else if (grant_q != '0)
            grant_q <= grant_q & ~done_i;
        else if (req_i != '0)
            grant_q <= pick_vec;
    end
endmodule

// File: rtl/bwshare_chk.sv
module bwshare_chk
    import bwshare_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       dyn_mode,
    input mvec_t      req,
    input mvec_t      done,
    input mvec_t      grant,
    input share_vec_t share_vec,
    input eff_vec_t   eff_vec
);
    function automatic int sum_share(share_vec_t s);
        int t = 0;
        for (int i = 0; i < NM; i++) t += int'(s[i]);
        return t;
    endfunction

    function automatic int sum_eff(eff_vec_t e);
        int t = 0;
        for (int i = 0; i < NM; i++) t += int'(e[i]);
        return t;
    endfunction

    assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    for (genvar g = 0; g < NM; g++) begin : g_m
        assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
            (grant[g] && !done[g]) |=> grant[g]);
        assert_release_R2: assert property (@(posedge clk) disable iff (rst)
            (grant[g] && done[g]) |=> !grant[g]);
    end

    assert_start_R3: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && grant != $past(grant))
            |-> ($past(grant) == '0 && ($past(req) & grant) != '0));

    assert_static_R8: assert property (@(posedge clk) disable iff (rst)
        (!dyn_mode && $past(!dyn_mode))
            |-> (sum_eff(eff_vec) == sum_share(share_vec) && eff_vec[0] == EFF_W'(share_vec[0])
                 && eff_vec[NM-1] == EFF_W'(share_vec[NM-1])));

    assert_conserve_R9: assert property (@(posedge clk) disable iff (rst)
        sum_eff(eff_vec) == sum_share(share_vec));
endmodule

bind bw_share_arbiter bwshare_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .dyn_mode  (dyn_mode),
    .req       (req_i),
    .done      (done_i),
    .grant     (grant_o),
    .share_vec (share_vec),
    .eff_vec   (eff_vec)
);

// File: tb/bw_share_arbiter_tb.sv
`timescale 1ns/1ps
module bw_share_arbiter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dyn_mode = 1'b0;
    logic [3:0]  req = '0;
    logic [3:0]  done = '0;
    logic [27:0] share_cfg = '0;
    logic [3:0]  grant;

    int checks = 0;
    int fails  = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    bw_share_arbiter u_dut (
        .clk         (clk),
        .rst         (rst),
        .dyn_mode    (dyn_mode),
        .req_i       (req),
        .done_i      (done),
        .share_cfg_i (share_cfg),
        .grant_o     (grant)
    );

    // {s3, s2, s1, s0, request, expected grant}
    localparam int NV = 9;
    localparam logic [35:0] VEC [NV] = '{
        {7'd52, 7'd32, 7'd8,  7'd8,  4'b0001, 4'b0001},
        {7'd52, 7'd32, 7'd8,  7'd8,  4'b0100, 4'b0100},
        {7'd52, 7'd32, 7'd8,  7'd8,  4'b1111, 4'b1000},
        {7'd52, 7'd32, 7'd8,  7'd8,  4'b0011, 4'b0001},
        {7'd10, 7'd60, 7'd15, 7'd15, 4'b1110, 4'b0100},
        {7'd100,7'd0,  7'd0,  7'd0,  4'b0011, 4'b0001},
        {7'd60, 7'd0,  7'd40, 7'd0,  4'b0101, 4'b0001},
        {7'd60, 7'd0,  7'd40, 7'd0,  4'b0100, 4'b0100},
        {7'd60, 7'd0,  7'd40, 7'd0,  4'b0110, 4'b0010}
    };

    function automatic string vec_tag(int k);
        case (k)
            0, 1, 7: return "R4 single requester";
            2, 3, 4, 8: return "R5 below-target priority";
            default: return "R6 none below target";
        endcase
    endfunction

    task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: grant=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic set_shares(int s0, int s1, int s2, int s3);
        share_cfg = {7'(s3), 7'(s2), 7'(s1), 7'(s0)};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req = '0; done = '0;
        repeat (2) @(negedge clk);
        check("R1 reset grant", grant, 4'b0000);
        rst = 1'b0;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog R1-related run hang: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // vector table: fresh usage after reset, static mode
        for (int k = 0; k < NV; k++) begin
            dyn_mode = 1'b0;
            share_cfg = VEC[k][35:8];
            do_reset();
            req = VEC[k][7:4];
            step(1);
            check(vec_tag(k), grant, VEC[k][3:0]);
            done = grant; req = '0;
            step(1);
            done = '0;
        end

        // R2 hold and release, R3 restart after idle cycle
        set_shares(8, 8, 32, 52);
        do_reset();
        req = 4'b0001;
        step(1);
        check("R4 lone request", grant, 4'b0001);
        req = 4'b1111;
        for (int c = 0; c < 4; c++) begin
            step(1);
            check("R2 grant held", grant, 4'b0001);
        end
        done = 4'b0001;
        step(1);
        check("R2 released on done", grant, 4'b0000);
        done = '0;
        step(1);
        check("R3 new arbitration", grant, 4'b1000);
        done = grant; req = '0;
        step(1);
        done = '0;
        step(2);
        check("R3 no request no grant", grant, 4'b0000);

        // R5/R7: measured usage beats configured priority, then window drains
        set_shares(5, 85, 0, 10);
        do_reset();
        req = 4'b1000;
        step(1);
        check("R4 lone request", grant, 4'b1000);
        req = 4'b1001;
        step(40);
        done = 4'b1000;
        step(1);
        done = '0;
        step(1);
        check("R7 over-target master loses", grant, 4'b0001);
        done = 4'b0001; req = '0;
        step(1);
        done = '0;
        step(300);
        req = 4'b1001;
        step(1);
        check("R7 usage aged out of window", grant, 4'b1000);
        done = grant; req = '0;
        step(1);
        done = '0;

        // R8: static mode, starving master gets no help
        set_shares(0, 70, 0, 30);
        dyn_mode = 1'b0;
        do_reset();
        req = 4'b1000;
        step(1);
        req = 4'b1001;
        step(100);
        done = 4'b1000;
        step(1);
        done = '0;
        step(1);
        check("R8 static no borrowing", grant, 4'b1000);
        done = grant; req = '0;
        step(1);
        done = '0;

        // R9/R10: dynamic borrowing, then loan returned
        dyn_mode = 1'b1;
        do_reset();
        req = 4'b1000;
        step(1);
        check("R4 lone request", grant, 4'b1000);
        req = 4'b1001;
        step(100);
        done = 4'b1000;
        step(1);
        done = '0;
        step(1);
        check("R9 starving master borrows share", grant, 4'b0001);
        done = 4'b0001;
        step(1);
        done = '0;
        step(1);
        check("R10 loan returned after grant", grant, 4'b1000);
        done = grant; req = '0;
        step(1);
        done = '0;
        dyn_mode = 1'b0;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule